// File: doc/BRIEF.md
# Dual-Segment Relocation and Protection Unit

This block turns a logical operand address into a physical address using two base/length register pairs. One pair describes a private partition that holds the running program's writable data. The other describes a sharable partition that holds code and read-only data. The offset into the chosen partition is the index-register value plus the displacement. The physical address is the partition base plus that offset. An offset at or beyond the partition length is refused. A write aimed at the sharable partition is also refused.

A mode input chooses how the partition is selected. In address-bit mode, the top bit of the logical address picks the partition, and that bit is removed before the offset is formed. In access-type mode, instruction fetches go to the sharable partition and data references go to the private one, with no selector bit taken from the address. A privileged configuration port loads the four registers. The request path has no means of changing them. Each accepted request produces exactly one registered result on the following cycle: either a valid physical address or a protection fault with a code.

Top module: `dseg_reloc_unit`

## Requirements
- R1: While `rst` is high, `rsp_valid`, `rsp_err`, `rsp_code` and `rsp_paddr` are all zero on the following edge. A configuration write during reset is ignored. After reset all four registers read as zero, so every request faults with a bounds code.
- R2: When `cfg_we` is high, `cfg_slot` picks the register to load: 0 is the private base, 1 is the private length, 2 is the sharable base, 3 is the sharable length. A load is seen by requests in later cycles. A request in the same cycle as a load uses the value held before the load.
- R3: The offset is `req_index` plus the displacement, formed at LADDR_W+1 bits so that the carry is kept. On success, `rsp_paddr` is (selected base + offset) modulo 2^PADDR_W.
- R4: With `sel_mode`=0, a logical-address top bit of 1 selects the sharable pair and 0 selects the private pair. The displacement is the logical address with its top bit cleared.
- R5: With `sel_mode`=1, access kind 0 (fetch) selects the sharable pair. Kinds 1 (read), 2 (write) and 3 (treated as read) select the private pair. The displacement is the whole logical address.
- R6: If the offset is greater than or equal to the selected length, the result is `rsp_err`=1 with `rsp_code`=1, `rsp_valid`=0 and `rsp_paddr`=0. An offset of length-1 is accepted.
- R7: A write (kind 2) to the sharable pair that is in bounds gives `rsp_err`=1 with `rsp_code`=2 and `rsp_paddr`=0. If such a write is also out of bounds, the code is 1. Writes to the private pair are allowed.
- R8: A request with `req_valid`=1 produces exactly one of `rsp_valid` or `rsp_err` on the next cycle, with `rsp_code`=0 on success. A cycle without a request produces neither. Back-to-back requests are answered one per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration register load strobe |
| cfg_slot | input | 2 | Register picked by a load |
| cfg_data | input | PADDR_W | Value to load |
| sel_mode | input | 1 | 0: address-bit selection, 1: access-type selection |
| req_valid | input | 1 | Request strobe |
| req_kind | input | 2 | Access kind: 0 fetch, 1 read, 2 write |
| req_laddr | input | LADDR_W | Logical address (displacement) |
| req_index | input | LADDR_W | Index-register value |
| rsp_valid | output | 1 | Translated access allowed |
| rsp_err | output | 1 | Protection fault |
| rsp_code | output | 2 | 0 none, 1 bounds, 2 write to sharable |
| rsp_paddr | output | PADDR_W | Physical address, zero unless valid |

## Verification
The assertions check four things on every clock. Each request yields exactly one outcome and idle cycles yield none. An allowed access always had its offset below the selected length and was never a write to the sharable partition. The code agrees with the outcome strobe. The registers hold when no load is strobed. Only the bench's scenarios can show the arithmetic values of the physical address, the carry into the extra offset bit, the correct partition choice in each mode, and the exact boundary at length-1 versus length. The same applies to the same-cycle ordering of a load and a request, and to loads ignored during reset. The bench's reference model checks all of these against the outputs on each cycle.

// File: rtl/dsru_pkg.sv
package dsru_pkg;
  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_kind_e;

  typedef enum logic [1:0] {
    FLT_NONE   = 2'd0,
    FLT_BOUNDS = 2'd1,
    FLT_WPROT  = 2'd2
  } flt_code_e;

  typedef enum logic {
    SEL_ADDRBIT = 1'b0,
    SEL_ACCTYPE = 1'b1
  } sel_mode_e;

  // slot index: {pair, is_length}
  localparam int unsigned PAIR_PRIV  = 0;
  localparam int unsigned PAIR_SHARE = 1;
  localparam int unsigned NUM_PAIRS  = 2;
endpackage

// File: rtl/dsru_bank.sv
module dsru_bank
  import dsru_pkg::*;
#(
  parameter int unsigned PADDR_W = 20
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              cfg_we,
  input  logic [1:0]                        cfg_slot,
  input  logic [PADDR_W-1:0]                cfg_data,
  output logic [NUM_PAIRS-1:0][PADDR_W-1:0] base_q,
  output logic [NUM_PAIRS-1:0][PADDR_W-1:0] len_q
);
  for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_pair
    localparam logic PAIR_BIT = (g == PAIR_SHARE);
    always_ff @(posedge clk) begin
      if (rst) begin
        base_q[g] <= '0;
        len_q[g]  <= '0;
      end else if (cfg_we && cfg_slot[1] == PAIR_BIT) begin
        if (cfg_slot[0]) len_q[g]  <= cfg_data;
        else             base_q[g] <= cfg_data;
      end
    end
  end

  AST_REGS_HOLD: assert property (@(posedge clk) disable iff (rst)
    !cfg_we |=> ($stable(base_q) && $stable(len_q))); // R2
endmodule

// File: rtl/dsru_route.sv
module dsru_route
  import dsru_pkg::*;
#(
  parameter int unsigned LADDR_W = 16
) (
  input  logic               mode,
  input  logic [1:0]         kind,
  input  logic [LADDR_W-1:0] laddr,
  output logic               shared,
  output logic [LADDR_W-1:0] disp
);
  always_comb begin
    if (sel_mode_e'(mode) == SEL_ACCTYPE) begin
      shared = (acc_kind_e'(kind) == ACC_FETCH);
      disp   = laddr;
    end else begin
      shared = laddr[LADDR_W-1];
      disp   = {1'b0, laddr[LADDR_W-2:0]};
    end
  end
endmodule

// File: rtl/dsru_guard.sv
module dsru_guard
  import dsru_pkg::*;
#(
  parameter int unsigned LADDR_W = 16,
  parameter int unsigned PADDR_W = 20,
  localparam int unsigned OFF_W  = LADDR_W + 1,
  localparam int unsigned CMP_W  = (OFF_W > PADDR_W) ? OFF_W : PADDR_W
) (
  input  logic                              shared,
  input  logic [1:0]                        kind,
  input  logic [LADDR_W-1:0]                disp,
  input  logic [LADDR_W-1:0]                index,
  input  logic [NUM_PAIRS-1:0][PADDR_W-1:0] base_q,
  input  logic [NUM_PAIRS-1:0][PADDR_W-1:0] len_q,
  output logic [CMP_W-1:0]                  off_ext,
  output logic [CMP_W-1:0]                  lim_ext,
  output logic [PADDR_W-1:0]                paddr,
  output logic [1:0]                        code
);
  logic [OFF_W-1:0]   offset;
  logic [PADDR_W-1:0] sel_base;
  logic               oob;
  logic               wprot;

  always_comb begin
    offset   = {1'b0, index} + {1'b0, disp};
    sel_base = shared ? base_q[PAIR_SHARE] : base_q[PAIR_PRIV];
    off_ext  = CMP_W'(offset);
    lim_ext  = CMP_W'(shared ? len_q[PAIR_SHARE] : len_q[PAIR_PRIV]);
    oob      = (off_ext >= lim_ext);
    wprot    = shared && (acc_kind_e'(kind) == ACC_WRITE);
    paddr    = sel_base + PADDR_W'(offset);
    if (oob)        code = FLT_BOUNDS;
    else if (wprot) code = FLT_WPROT;
    else            code = FLT_NONE;
  end
endmodule

// File: rtl/dseg_reloc_unit.sv
module dseg_reloc_unit
  import dsru_pkg::*;
#(
  parameter int unsigned LADDR_W = 16,
  parameter int unsigned PADDR_W = 20
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_we,
  input  logic [1:0]         cfg_slot,
  input  logic [PADDR_W-1:0] cfg_data,
  input  logic               sel_mode,
  input  logic               req_valid,
  input  logic [1:0]         req_kind,
  input  logic [LADDR_W-1:0] req_laddr,
  input  logic [LADDR_W-1:0] req_index,
  output logic               rsp_valid,
  output logic               rsp_err,
  output logic [1:0]         rsp_code,
  output logic [PADDR_W-1:0] rsp_paddr
);
  localparam int unsigned OFF_W = LADDR_W + 1;
  localparam int unsigned CMP_W = (OFF_W > PADDR_W) ? OFF_W : PADDR_W;

  logic [NUM_PAIRS-1:0][PADDR_W-1:0] base_q;
  logic [NUM_PAIRS-1:0][PADDR_W-1:0] len_q;
  logic                              shared;
  logic [LADDR_W-1:0]                disp;
  logic [CMP_W-1:0]                  off_ext;
  logic [CMP_W-1:0]                  lim_ext;
  logic [PADDR_W-1:0]                paddr;
  logic [1:0]                        code;
  logic                              ok;

  dsru_bank #(.PADDR_W(PADDR_W)) u_bank (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_slot(cfg_slot),
    .cfg_data(cfg_data), .base_q(base_q), .len_q(len_q)
  );

  dsru_route #(.LADDR_W(LADDR_W)) u_route (
    .mode(sel_mode), .kind(req_kind), .laddr(req_laddr),
    .shared(shared), .disp(disp)
  );

  dsru_guard #(.LADDR_W(LADDR_W), .PADDR_W(PADDR_W)) u_guard (
    .shared(shared), .kind(req_kind), .disp(disp), .index(req_index),
    .base_q(base_q), .len_q(len_q), .off_ext(off_ext), .lim_ext(lim_ext),
    .paddr(paddr), .code(code)
  );

  assign ok = (flt_code_e'(code) == FLT_NONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_code  <= FLT_NONE;
      rsp_paddr <= '0;
    end else begin
      rsp_valid <= req_valid && ok;
      rsp_err   <= req_valid && !ok;
      rsp_code  <= req_valid ? code : FLT_NONE;
      rsp_paddr <= (req_valid && ok) ? paddr : '0;
    end
  end

  AST_ONE_RESULT: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> (rsp_valid ^ rsp_err)); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!rsp_valid && !rsp_err)); // R8
  AST_IN_BOUNDS: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> ($past(off_ext) < $past(lim_ext))); // R6
  AST_NO_SHARED_WRITE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !($past(shared) && $past(req_kind) == ACC_WRITE)); // R7
  AST_CODE_MATCH: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> (rsp_code != FLT_NONE && rsp_paddr == '0)); // R6
  AST_BOUNDS_FIRST: assert property (@(posedge clk) disable iff (rst)
    (rsp_code == FLT_WPROT) |-> ($past(off_ext) < $past(lim_ext))); // R7
endmodule

// File: tb/dseg_reloc_unit_test.sv
`timescale 1ns/1ps
module dseg_reloc_unit_test;
  localparam int LW = 16;
  localparam int PW = 20;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_slot = '0;
  logic [PW-1:0] cfg_data = '0;
  logic          sel_mode = 1'b0;
  logic          req_valid = 1'b0;
  logic [1:0]    req_kind = '0;
  logic [LW-1:0] req_laddr = '0;
  logic [LW-1:0] req_index = '0;
  logic          rsp_valid, rsp_err;
  logic [1:0]    rsp_code;
  logic [PW-1:0] rsp_paddr;

  int compared = 0;
  int mismatched = 0;
  longint m_reg [4];

  always #2.5 clk = ~clk;

  dseg_reloc_unit #(.LADDR_W(LW), .PADDR_W(PW)) uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_slot(cfg_slot),
    .cfg_data(cfg_data), .sel_mode(sel_mode), .req_valid(req_valid),
    .req_kind(req_kind), .req_laddr(req_laddr), .req_index(req_index),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_code(rsp_code),
    .rsp_paddr(rsp_paddr)
  );

  // Called just after a falling edge: drive, predict, wait one cycle, compare.
  task automatic step(input string tag, input bit we, input int slot,
                      input longint data, input bit rv, input int kind,
                      input bit mode, input longint la, input longint ix);
    bit ev, ee;
    int ec;
    longint ep, disp, off, lim, base;
    bit sh;
    cfg_we = we; cfg_slot = 2'(slot); cfg_data = PW'(data);
    req_valid = rv; req_kind = 2'(kind); sel_mode = mode;
    req_laddr = LW'(la); req_index = LW'(ix);
    ev = 0; ee = 0; ec = 0; ep = 0;
    if (!rst && rv) begin
      if (mode) begin sh = (kind == 0); disp = la; end
      else begin sh = la[LW-1]; disp = la & ((64'd1 << (LW-1)) - 1); end
      off  = ix + disp;
      base = sh ? m_reg[2] : m_reg[0];
      lim  = sh ? m_reg[3] : m_reg[1];
      if (off >= lim) begin ee = 1; ec = 1; end
      else if (sh && kind == 2) begin ee = 1; ec = 2; end
      else begin ev = 1; ep = (base + off) % (64'd1 << PW); end
    end
    if (we && !rst) m_reg[slot] = data;
    @(negedge clk);
    compared++;
    if (rsp_valid !== ev || rsp_err !== ee || rsp_code !== 2'(ec) ||
        rsp_paddr !== PW'(ep)) begin
      mismatched++;
      $display("FAIL %s: got v=%0b e=%0b code=%0d paddr=%h, expected v=%0b e=%0b code=%0d paddr=%h",
               tag, rsp_valid, rsp_err, rsp_code, rsp_paddr, ev, ee, ec, PW'(ep));
    end
  endtask

  task automatic load(input string tag, input int slot, input longint v);
    step(tag, 1, slot, v, 0, 0, 0, 0, 0);
  endtask

  task automatic req(input string tag, input int kind, input bit mode,
                     input longint la, input longint ix);
    step(tag, 0, 0, 0, 1, kind, mode, la, ix);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) m_reg[i] = 0;
    @(negedge clk);
    // R1: reset clears outputs; loads during reset are ignored
    step("R1", 1, 1, 20'h00400, 1, 1, 1, 0, 0);
    step("R1", 0, 0, 0, 0, 0, 0, 0, 0);
    rst = 1'b0;
    req("R1", 1, 1, 16'h0000, 0);
    // R2: load all four registers
    load("R2", 0, 20'h01000);
    load("R2", 1, 20'h20000);
    load("R2", 2, 20'h40000);
    load("R2", 3, 20'h02000);
    // R3: index plus displacement with carry into the extra bit
    req("R3", 1, 1, 16'hFFFF, 16'h0003);
    req("R3", 2, 1, 16'h1234, 16'h0010);
    // R4: address-bit selection with selector stripped
    req("R4", 1, 0, 16'h8100, 16'h0000);
    req("R4", 1, 0, 16'h0100, 16'h0000);
    req("R4", 0, 0, 16'h0040, 16'h0002);
    // R5: access-type selection
    req("R5", 0, 1, 16'h0100, 16'h0001);
    req("R5", 3, 1, 16'h0100, 16'h0001);
    req("R5", 1, 1, 16'h8100, 16'h0000);
    // R6: exact limit on the sharable pair (length 0x2000)
    req("R6", 0, 1, 16'h1FFF, 16'h0000);
    req("R6", 0, 1, 16'h1FFF, 16'h0001);
    req("R6", 1, 0, 16'hA000, 16'h0000);
    // R7: write protection and priority
    req("R7", 2, 0, 16'h8010, 16'h0000);
    req("R7", 2, 0, 16'hA000, 16'h0000);
    req("R7", 2, 0, 16'h0010, 16'h0000);
    // R2: same-cycle load and request sees old length, next sees new
    step("R2", 1, 1, 20'h00010, 1, 1, 1, 16'h0100, 0);
    req("R2", 1, 1, 16'h0100, 0);
    load("R2", 1, 20'h20000);
    // R8: idle cycles and back-to-back requests
    step("R8", 0, 0, 0, 0, 2, 0, 16'h8000, 0);
    step("R8", 0, 0, 0, 0, 0, 1, 0, 0);
    for (int i = 0; i < 8; i++) req("R8", i % 3, i[0], 16'h0400 * i, i);
    // R3: mixed random traffic with occasional reloads
    for (int i = 0; i < 600; i++) begin
      bit we = ($urandom % 8) == 0;
      step("R3", we, $urandom % 4, $urandom % (1 << PW), ($urandom % 4) != 0,
           $urandom % 4, $urandom % 2, $urandom % (1 << LW),
           ($urandom % 2) ? ($urandom % 256) : ($urandom % (1 << LW)));
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #1000000;
    mismatched++;
    $display("FAIL watchdog: got hung run, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule